// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on an 8-bit special-function-register bus and launches erase cycles in an external flash array. Software first unlocks an erase by writing a register, then writes a magic byte to a write-only command address. A page erase needs a page-number write followed by the page magic byte. A mass erase needs a write to the mass-enable register, the mass magic byte, and an asserted debug-enable input.

When the checks pass, the block sends one request strobe to the flash interface. The strobe carries a mode bit and a 7-bit page number. The block then reports busy until the array returns a done pulse. Command writes that fail the checks change nothing except the unlock state, and they raise no error. Each unlock is used once, so every erase needs a fresh unlock.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy` and `erase_req` are low, and a read of the page register (0xB7) returns 0x00.
- R2: A write to the page register (0xB7) stores the low 7 bits of the data. A read returns them with bit 7 forced to 0. A read of the command address (0x94) always returns 0x00.
- R3: When the page unlock is armed, writing 0x55 to 0x94 while idle raises `erase_req` for the cycle after the write edge. In that cycle `erase_mass` is 0 (page mode), `erase_page` holds the stored page number, and `busy` is high.
- R4: Writing 0x55 when no page-register write has armed the page unlock starts nothing.
- R5: When the mass unlock is armed (any write to 0xB2) and `dbg_en` is high, writing 0xAA to 0x94 while idle raises `erase_req` with `erase_mass` = 1, and `busy` goes high.
- R6: Writing 0xAA while `dbg_en` is low starts nothing and disarms the unlock. A later 0xAA with `dbg_en` high also starts nothing until a new write to 0xB2.
- R7: While idle, a command byte other than 0x55 or 0xAA starts nothing and disarms both unlocks. The same applies to a magic byte whose condition is not met.
- R8: Issuing an erase consumes its unlock. A repeat of the same magic byte without a new unlock write starts nothing.
- R9: `busy` stays high until `erase_done` is sampled high, and falls on the next edge. While busy, command writes are ignored and leave the unlock state unchanged, and `erase_mass` and `erase_page` hold steady.
- R10: `erase_req` is high for exactly one cycle per erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_rdata | output | 8 | Register bus read data (combinational on address) |
| dbg_en | input | 1 | Debug-enable condition required for mass erase |
| erase_req | output | 1 | One-cycle erase request strobe to the flash array |
| erase_mass | output | 1 | Request mode: 1 = mass erase, 0 = page erase |
| erase_page | output | 7 | Page number of the request |
| erase_done | input | 1 | Completion pulse from the flash array |
| busy | output | 1 | High while an erase is outstanding |

## Verification
The assertions check several rules on every cycle:
- the request is a single-cycle strobe that is only issued from idle;
- a mass request always had the debug enable present at its write edge;
- mode and page hold steady while busy;
- busy cannot drop without a done pulse;
- the read-back MSB is always zero.

Only the bench's scenarios can show the unlock rules. These are: consumption of an unlock, disarming by a wrong byte or by an unmet condition, and the preservation of unlock state across writes ignored while busy. Each of these needs a specific history of register writes.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] CMD_PAGE_KEY = 8'h55;
  localparam logic [7:0] CMD_MASS_KEY = 8'hAA;

  typedef enum logic { MODE_PAGE = 1'b0, MODE_MASS = 1'b1 } erase_mode_e;

  function automatic logic is_page_key(input logic [7:0] b);
    return b == CMD_PAGE_KEY;
  endfunction

  function automatic logic is_mass_key(input logic [7:0] b);
    return b == CMD_MASS_KEY;
  endfunction

  function automatic logic [7:0] page_readback(input logic [6:0] pg);
    return {1'b0, pg};
  endfunction
endpackage

// File: rtl/fe_unlock_regs.sv
module fe_unlock_regs #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_page,
  input  logic [PW-1:0] wr_page_val,
  input  logic          wr_meen,
  input  logic          use_page,
  input  logic          use_mass,
  input  logic          disarm_all,
  output logic [PW-1:0] page_q,
  output logic          page_armed,
  output logic          mass_armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
    end else begin
      if (wr_page) begin
        page_q     <= wr_page_val;
        page_armed <= 1'b1;
      end else if (use_page || disarm_all) begin
        page_armed <= 1'b0;
      end
      if (wr_meen)
        mass_armed <= 1'b1;
      else if (use_mass || disarm_all)
        mass_armed <= 1'b0;
    end
  end

  AST_PAGE_ARM_USED: assert property (@(posedge clk) disable iff (!rst_n)
    use_page && !wr_page |=> !page_armed); // R8
  AST_MASS_ARM_USED: assert property (@(posedge clk) disable iff (!rst_n)
    use_mass && !wr_meen |=> !mass_armed); // R8
endmodule

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode (
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       page_armed,
  input  logic       mass_armed,
  input  logic       dbg_en,
  input  logic       busy,
  output logic       go_page,
  output logic       go_mass,
  output logic       disarm_all
);
  import fe_pkg::*;
  logic live;

  always_comb begin
    live       = cmd_wr && !busy;
    go_page    = live && is_page_key(cmd_byte) && page_armed;
    go_mass    = live && is_mass_key(cmd_byte) && mass_armed && dbg_en;
    disarm_all = live && !go_page && !go_mass;
  end

  always_comb begin
    AST_GO_EXCLUSIVE: assert (!(go_page && go_mass)); // R3
  end
endmodule

// File: rtl/fe_issue.sv
module fe_issue #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_page,
  input  logic          go_mass,
  input  logic [PW-1:0] page_q,
  input  logic          dbg_en,
  input  logic          done,
  output logic          req,
  output logic          mass,
  output logic [PW-1:0] page,
  output logic          busy
);
  import fe_pkg::*;
  erase_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      busy   <= 1'b0;
      mode_q <= MODE_PAGE;
      page   <= '0;
    end else begin
      req <= 1'b0;
      if (busy) begin
        if (done) busy <= 1'b0;
      end else if (go_page || go_mass) begin
        req    <= 1'b1;
        busy   <= 1'b1;
        mode_q <= go_mass ? MODE_MASS : MODE_PAGE;
        page   <= page_q;
      end
    end
  end

  assign mass = (mode_q == MODE_MASS);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req); // R10
  AST_REQ_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req); // R3
  AST_MASS_NEEDS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    req && mass |-> $past(dbg_en)); // R5
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy); // R9
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req |-> $stable(page) && $stable(mass)); // R9
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int          AW        = 8,
  parameter int          PW        = 7,
  parameter logic [7:0]  ADDR_CMD  = 8'h94,
  parameter logic [7:0]  ADDR_PAGE = 8'hB7,
  parameter logic [7:0]  ADDR_MEEN = 8'hB2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sfr_addr,
  input  logic [7:0]    sfr_wdata,
  input  logic          sfr_we,
  output logic [7:0]    sfr_rdata,
  input  logic          dbg_en,
  output logic          erase_req,
  output logic          erase_mass,
  output logic [PW-1:0] erase_page,
  input  logic          erase_done,
  output logic          busy
);
  import fe_pkg::*;

  logic          hit_cmd, hit_page, hit_meen;
  logic          wr_cmd, wr_page, wr_meen;
  logic [PW-1:0] page_q;
  logic          page_armed, mass_armed;
  logic          go_page, go_mass, disarm_all;

  assign hit_cmd  = (sfr_addr == AW'(ADDR_CMD));
  assign hit_page = (sfr_addr == AW'(ADDR_PAGE));
  assign hit_meen = (sfr_addr == AW'(ADDR_MEEN));
  assign wr_cmd   = sfr_we && hit_cmd;
  assign wr_page  = sfr_we && hit_page;
  assign wr_meen  = sfr_we && hit_meen;

  fe_unlock_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_page(wr_page), .wr_page_val(sfr_wdata[PW-1:0]), .wr_meen(wr_meen),
    .use_page(go_page), .use_mass(go_mass), .disarm_all(disarm_all),
    .page_q(page_q), .page_armed(page_armed), .mass_armed(mass_armed)
  );

  fe_cmd_decode u_dec (
    .cmd_wr(wr_cmd), .cmd_byte(sfr_wdata),
    .page_armed(page_armed), .mass_armed(mass_armed),
    .dbg_en(dbg_en), .busy(busy),
    .go_page(go_page), .go_mass(go_mass), .disarm_all(disarm_all)
  );

  fe_issue #(.PW(PW)) u_iss (
    .clk(clk), .rst_n(rst_n),
    .go_page(go_page), .go_mass(go_mass), .page_q(page_q),
    .dbg_en(dbg_en), .done(erase_done),
    .req(erase_req), .mass(erase_mass), .page(erase_page), .busy(busy)
  );

  always_comb begin
    if (hit_page) sfr_rdata = page_readback(page_q);
    else          sfr_rdata = 8'h00;
  end

  AST_RDATA_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sfr_rdata[7]); // R2
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_cmd |=> !erase_req); // R9
endmodule

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_rdata;
  logic       dbg_en = 1'b0;
  logic       erase_req, erase_mass, busy;
  logic [6:0] erase_page;
  logic       erase_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [7:0] A_CMD = 8'h94, A_PAGE = 8'hB7, A_MEEN = 8'hB2;

  always #4 clk = ~clk;

  flash_erase_seq u0 (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .dbg_en(dbg_en),
    .erase_req(erase_req), .erase_mass(erase_mass), .erase_page(erase_page),
    .erase_done(erase_done), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, captured at the next rising edge; returns at the
  // following falling edge, where registered results are visible.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic finish_erase();
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 busy", busy, 0);
    check("R1 req", erase_req, 0);
    rd(A_PAGE, d);
    check("R1 page read", d, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    wr(A_PAGE, 8'hFF);
    rd(A_PAGE, d);
    check("R2 page bit7 masked", d, 8'h7F);
    rd(A_CMD, d);
    check("R2 cmd reads zero", d, 8'h00);
  endtask

  task automatic t_page_erase();
    wr(A_PAGE, 8'h25);
    wr(A_CMD, 8'h55);
    check("R3 req", erase_req, 1);
    check("R3 mode page", erase_mass, 0);
    check("R3 page num", erase_page, 7'h25);
    check("R3 busy", busy, 1);
    @(negedge clk);
    check("R10 req drops", erase_req, 0);
    check("R9 busy held", busy, 1);
    wr(A_PAGE, 8'h10);
    wr(A_CMD, 8'h55);
    check("R9 cmd ignored when busy", erase_req, 0);
    check("R9 page stable", erase_page, 7'h25);
    repeat (3) @(negedge clk);
    check("R9 busy waits done", busy, 1);
    finish_erase();
    check("R9 busy cleared", busy, 0);
    // unlock armed while busy survived the ignored write
    wr(A_CMD, 8'h55);
    check("R9 arm kept across busy", erase_req, 1);
    check("R3 new page", erase_page, 7'h10);
    finish_erase();
    wr(A_CMD, 8'h55);
    check("R8 unlock consumed", erase_req, 0);
    check("R8 still idle", busy, 0);
  endtask

  task automatic t_no_arm();
    wr(A_CMD, 8'h55);
    check("R4 no page arm", erase_req, 0);
    wr(A_MEEN, 8'h01);
    wr(A_CMD, 8'h55);
    check("R4 mass arm only", erase_req, 0);
  endtask

  task automatic t_mass();
    dbg_en = 1'b1;
    wr(A_MEEN, 8'h01);
    wr(A_CMD, 8'hAA);
    check("R5 req", erase_req, 1);
    check("R5 mode mass", erase_mass, 1);
    check("R5 busy", busy, 1);
    @(negedge clk);
    check("R10 mass req one cycle", erase_req, 0);
    finish_erase();
    wr(A_CMD, 8'hAA);
    check("R8 mass unlock consumed", erase_req, 0);
  endtask

  task automatic t_mass_nodbg();
    dbg_en = 1'b0;
    wr(A_MEEN, 8'h01);
    wr(A_CMD, 8'hAA);
    check("R6 no dbg", erase_req, 0);
    dbg_en = 1'b1;
    wr(A_CMD, 8'hAA);
    check("R6 disarmed", erase_req, 0);
    check("R6 idle", busy, 0);
  endtask

  task automatic t_other();
    dbg_en = 1'b1;
    wr(A_PAGE, 8'h05);
    wr(A_MEEN, 8'h01);
    wr(A_CMD, 8'h12);
    check("R7 bad byte", erase_req, 0);
    check("R7 idle", busy, 0);
    wr(A_CMD, 8'h55);
    check("R7 page disarmed", erase_req, 0);
    wr(A_CMD, 8'hAA);
    check("R7 mass disarmed", erase_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_page_erase();
    t_no_arm();
    t_mass();
    t_mass_nodbg();
    t_other();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule